// File: doc/BRIEF.md
# I2C Bit-Rate Divider with Best-Fit Search

This block produces the sub-bit tick that paces an I2C byte engine. The tick is derived from the system clock through a two-field rate code. A 4-bit linear factor `m` scales the period by `m+1`. A 3-bit exponent `n` scales it by a power of two. Ten ticks make one SCL bit, so the bus rate is the system clock divided by ten times the tick period.

The block also contains a search engine. It is given the system clock frequency and a requested bus rate, both in hertz. It steps through every rate code in a fixed order and computes the bus rate each code would give. It keeps the fastest code that does not exceed the request, and writes that code into the rate register when it finishes. The rate register can also be written directly. A synchronous soft reset puts the register back to its default value and cancels any search in progress.

Top module: `brd_rate_gen`

## Requirements
- R1: The rate code packs the exponent `n` in bits [2:0] and the linear factor `m` in bits [6:3]. With the default build (`POW_ONE`=1), `tick` is high for one clock once every (m+1)·2^(n+1) clocks. With `POW_ONE`=0 the power-of-two factor is 2^n instead.
- R2: Hard reset and `soft_rst` both set the rate code to 0x44, which gives a tick period of 288 clocks. `soft_rst` takes priority over a direct write in the same cycle. It also aborts a running search, and no completion pulse follows.
- R3: A new rate code does not change the tick period already in progress. The new period starts at the next tick.
- R4: The search visits the codes with `n` stepping from 0 to 7 in the outer loop and `m` stepping from 0 to 15 in the inner loop. For each code it computes the candidate bus rate as floor(sys_hz / (10·period)).
- R5: The search accepts a candidate only when it is at most the requested rate and strictly greater than the best rate found so far. When two codes give the same rate, the one visited earlier is kept.
- R6: When no code qualifies, the search commits 0x44, whatever code was held before.
- R7: `srch_busy` is high from the clock edge that accepts `srch_go` until the search completes. `srch_done` is then a single-cycle pulse with `srch_busy` low. The found code appears on `baud_code` one clock later.
- R8: When a direct write and a search commit fall on the same edge, the written value wins.
- R9: A `srch_go` that arrives while a search is running is ignored. The running search finishes with its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restore to the default code, which also aborts a search |
| baud_we | input | 1 | Direct write strobe for the rate code |
| baud_wdata | input | 7 | Rate code to write: {m, n} |
| srch_go | input | 1 | Starts a best-fit search when the engine is idle |
| srch_req_hz | input | FREQ_W | Requested bus rate in Hz |
| srch_sys_hz | input | FREQ_W | System clock frequency in Hz |
| srch_busy | output | 1 | A search is in progress |
| srch_done | output | 1 | One-cycle pulse when a search completes |
| baud_code | output | 7 | Current rate code |
| tick | output | 1 | One-cycle tick, ten per SCL bit |

## Verification
Two functions can land on the same clock edge: the search committing its result and a direct write to the rate code. A third case is a soft reset meeting a direct write. To provoke the first case, the bench waits until it samples `srch_done` high and raises `baud_we` within that same cycle. The result is judged by reading `baud_code` on the following cycle, which must hold the written value and not the search result. The soft-reset case is provoked the same way, and `baud_code` must read 0x44.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int M_W           = 4;
  localparam int N_W           = 3;
  localparam int CODE_W        = M_W + N_W;
  localparam int NCAND         = 1 << CODE_W;
  localparam int PER_W         = M_W + (1 << N_W) + 1;
  localparam int DEN_W         = PER_W + 4;
  localparam int TICKS_PER_BIT = 10;
  localparam logic [CODE_W-1:0] CODE_RST = 7'h44;

  typedef logic [CODE_W-1:0] code_t;
  typedef enum logic [1:0] {SR_IDLE, SR_LAUNCH, SR_WAIT} srch_st_e;

  // tick period in system clocks for a rate code {m, n}
  function automatic logic [PER_W-1:0] period_of(code_t c, logic pow_one);
    int p;
    p = (int'(c[CODE_W-1:N_W]) + 1) << (int'(c[N_W-1:0]) + int'(pow_one));
    return p[PER_W-1:0];
  endfunction

  // clocks per SCL bit
  function automatic logic [DEN_W-1:0] divisor_of(code_t c, logic pow_one);
    int d;
    d = TICKS_PER_BIT * int'(period_of(c, pow_one));
    return d[DEN_W-1:0];
  endfunction

  // visit index: n in the high bits (outer), m in the low bits (inner)
  function automatic code_t code_of_index(code_t idx);
    return {idx[M_W-1:0], idx[CODE_W-1:M_W]};
  endfunction
endpackage

// File: rtl/brd_tick_gen.sv
module brd_tick_gen
  import brd_pkg::*;
#(
  parameter bit POW_ONE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  code_t code,
  output logic  tick
);
  localparam logic [PER_W-1:0] RST_LOAD = period_of(CODE_RST, POW_ONE) - 1'b1;

  logic [PER_W-1:0] cnt;

  assign tick = (cnt == '0);

  // reload only at a tick: a new code applies from the next boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= RST_LOAD;
    else if (restart) cnt <= RST_LOAD;
    else if (tick)    cnt <= period_of(code, POW_ONE) - 1'b1;
    else              cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/brd_seq_div.sv
module brd_seq_div #(
  parameter int DVD_W = 32,
  parameter int DSR_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DSR_W-1:0] dsr,
  output logic             done,
  output logic [DVD_W-1:0] quo
);
  localparam int STEP_W = $clog2(DVD_W + 1);

  logic [DSR_W-1:0]  rem;
  logic [DSR_W-1:0]  dsr_q;
  logic [STEP_W-1:0] left;
  logic [DSR_W:0]    trial;
  logic              fits;

  assign trial = {rem, quo[DVD_W-1]};
  assign fits  = (trial >= {1'b0, dsr_q});

  // restoring division: one quotient bit per clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      quo   <= '0;
      dsr_q <= '0;
      left  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        left <= '0;
      end else if (start) begin
        rem   <= '0;
        quo   <= dvd;
        dsr_q <= dsr;
        left  <= STEP_W'(DVD_W);
      end else if (left != '0) begin
        rem  <= fits ? DSR_W'(trial - {1'b0, dsr_q}) : trial[DSR_W-1:0];
        quo  <= {quo[DVD_W-2:0], fits};
        left <= left - 1'b1;
        done <= (left == STEP_W'(1));
      end
    end
  end
endmodule

// File: rtl/brd_fit_search.sv
module brd_fit_search
  import brd_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter bit POW_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              go,
  input  logic [FREQ_W-1:0] req_hz,
  input  logic [FREQ_W-1:0] sys_hz,
  output logic              busy,
  output logic              done,
  output code_t             fit_code,
  output logic [FREQ_W-1:0] fit_hz,
  output logic [FREQ_W-1:0] lim_hz
);
  srch_st_e          st;
  code_t             idx;
  logic [FREQ_W-1:0] req_q, sys_q, best_hz, cand_hz;
  code_t             best_code;
  logic [DEN_W-1:0]  cand_div;
  logic              div_start, div_done, take, last;

  assign div_start = (st == SR_LAUNCH);
  assign cand_div  = divisor_of(code_of_index(idx), POW_ONE);
  assign last      = (idx == code_t'(NCAND - 1));
  // strict improvement: an equal rate found later never replaces the earlier one
  assign take      = div_done && (cand_hz <= req_q) && (cand_hz > best_hz);
  assign busy      = (st != SR_IDLE);
  assign fit_code  = best_code;
  assign fit_hz    = best_hz;
  assign lim_hz    = req_q;

  brd_seq_div #(.DVD_W(FREQ_W), .DSR_W(DEN_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .start (div_start),
    .dvd   (sys_q),
    .dsr   (cand_div),
    .done  (div_done),
    .quo   (cand_hz)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SR_IDLE;
      idx       <= '0;
      req_q     <= '0;
      sys_q     <= '0;
      best_hz   <= '0;
      best_code <= CODE_RST;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        st <= SR_IDLE;
      end else begin
        case (st)
          SR_IDLE: if (go) begin
            req_q     <= req_hz;
            sys_q     <= sys_hz;
            idx       <= '0;
            best_hz   <= '0;
            best_code <= CODE_RST;
            st        <= SR_LAUNCH;
          end
          SR_LAUNCH: st <= SR_WAIT;
          SR_WAIT: if (div_done) begin
            if (take) begin
              best_hz   <= cand_hz;
              best_code <= code_of_index(idx);
            end
            if (last) begin
              st   <= SR_IDLE;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= SR_LAUNCH;
            end
          end
          default: st <= SR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/brd_rate_gen.sv
module brd_rate_gen
  import brd_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter bit POW_ONE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              baud_we,
  input  logic [6:0]        baud_wdata,
  input  logic              srch_go,
  input  logic [FREQ_W-1:0] srch_req_hz,
  input  logic [FREQ_W-1:0] srch_sys_hz,
  output logic              srch_busy,
  output logic              srch_done,
  output logic [6:0]        baud_code,
  output logic              tick
);
  code_t             baud_q;
  code_t             fit_code;
  logic [FREQ_W-1:0] fit_hz;
  logic [FREQ_W-1:0] lim_hz;

  brd_fit_search #(.FREQ_W(FREQ_W), .POW_ONE(POW_ONE)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (soft_rst),
    .go       (srch_go),
    .req_hz   (srch_req_hz),
    .sys_hz   (srch_sys_hz),
    .busy     (srch_busy),
    .done     (srch_done),
    .fit_code (fit_code),
    .fit_hz   (fit_hz),
    .lim_hz   (lim_hz)
  );

  brd_tick_gen #(.POW_ONE(POW_ONE)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (soft_rst),
    .code    (baud_q),
    .tick    (tick)
  );

  // priority: soft reset, then direct write, then search commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         baud_q <= CODE_RST;
    else if (soft_rst)  baud_q <= CODE_RST;
    else if (baud_we)   baud_q <= baud_wdata;
    else if (srch_done) baud_q <= fit_code;
  end

  assign baud_code = baud_q;
endmodule

// File: rtl/brd_rate_gen_chk.sv
module brd_rate_gen_chk #(
  parameter int FREQ_W  = 32,
  parameter bit POW_ONE = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              baud_we,
  input logic [6:0]        baud_wdata,
  input logic              srch_busy,
  input logic              srch_done,
  input logic [6:0]        baud_code,
  input logic              tick,
  input logic [6:0]        fit_code,
  input logic [FREQ_W-1:0] fit_hz,
  input logic [FREQ_W-1:0] lim_hz
);
  logic [15:0] gap;
  logic [15:0] exp_per;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      exp_per <= '0;
      seen    <= 1'b0;
    end else if (soft_rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap     <= 16'd1;
      seen    <= 1'b1;
      exp_per <= ({12'd0, baud_code[6:3]} + 16'd1) << ({1'b0, baud_code[2:0]} + 4'(POW_ONE));
    end else begin
      gap <= gap + 16'd1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (gap == exp_per)); // R1
  AST_SOFT_RST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (baud_code == 7'h44)); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(baud_we) && !$past(srch_done) && !$past(soft_rst)) |-> $stable(baud_code)); // R3
  AST_FIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> (fit_hz <= lim_hz)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |=> !srch_done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    srch_done |-> !srch_busy); // R7
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(srch_done) && !$past(baud_we) && !$past(soft_rst)) |-> (baud_code == $past(fit_code))); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(baud_we) && !$past(soft_rst)) |-> (baud_code == $past(baud_wdata))); // R8
endmodule

bind brd_rate_gen brd_rate_gen_chk #(.FREQ_W(FREQ_W), .POW_ONE(POW_ONE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .baud_we    (baud_we),
  .baud_wdata (baud_wdata),
  .srch_busy  (srch_busy),
  .srch_done  (srch_done),
  .baud_code  (baud_code),
  .tick       (tick),
  .fit_code   (fit_code),
  .fit_hz     (fit_hz),
  .lim_hz     (lim_hz)
);

// File: tb/sim_brd_rate_gen.sv
module sim_brd_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        baud_we = 1'b0;
  logic [6:0]  baud_wdata = '0;
  logic        srch_go = 1'b0;
  logic [31:0] srch_req_hz = '0;
  logic [31:0] srch_sys_hz = '0;
  logic        srch_busy, srch_done, tick;
  logic [6:0]  baud_code;

  int checks = 0;
  int failures = 0;
  int gap_v;
  int done_seen;

  // {system Hz, requested Hz, expected code}
  localparam logic [95:0] VEC [6] = '{
    {32'd100_000_000, 32'd100_000,    32'h62},  // period 104 is the tightest fit, R4
    {32'd100_000_000, 32'd2_500_000,  32'h08},  // period 4 twice: earlier visit wins, R5
    {32'd100_000_000, 32'd96_153,     32'h62},  // request equals a reachable rate, R5
    {32'd100_000_000, 32'd96_152,     32'h6A},  // period 112 twice: n=2,m=13 first, R5
    {32'd50_000_000,  32'd400_000,    32'h30},  // period 14, R4
    {32'd100_000_000, 32'hFFFF_FFFF,  32'h00}   // fastest code, R4
  };

  always #5 clk = ~clk;

  brd_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .baud_we(baud_we), .baud_wdata(baud_wdata),
    .srch_go(srch_go), .srch_req_hz(srch_req_hz), .srch_sys_hz(srch_sys_hz),
    .srch_busy(srch_busy), .srch_done(srch_done),
    .baud_code(baud_code), .tick(tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_code(input logic [6:0] c);
    @(negedge clk);
    baud_we = 1'b1;
    baud_wdata = c;
    @(negedge clk);
    baud_we = 1'b0;
  endtask

  task automatic pulse_go(input logic [31:0] sys, input logic [31:0] req);
    @(negedge clk);
    srch_sys_hz = sys;
    srch_req_hz = req;
    srch_go = 1'b1;
    @(negedge clk);
    srch_go = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 10000; k++) begin
      if (srch_done) break;
      @(negedge clk);
    end
  endtask

  task automatic run_search(input logic [31:0] sys, input logic [31:0] req);
    pulse_go(sys, req);
    wait_done();
    @(negedge clk);
  endtask

  task automatic measure_gap(output int g);
    g = 0;
    do @(negedge clk); while (!tick);
    do begin
      @(negedge clk);
      g++;
    end while (!tick && g < 10000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset code", int'(baud_code), 'h44);
    check("R7 idle after reset", int'(srch_busy), 0);
    measure_gap(gap_v);
    check("R1 default period 288", gap_v, 288);

    // vector table
    for (int i = 0; i < 6; i++) begin
      run_search(VEC[i][95:64], VEC[i][63:32]);
      check("R4/R5 search result", int'(baud_code), int'(VEC[i][6:0]));
    end

    // nothing qualifies: default comes back over a different code
    write_code(7'h13);
    check("R6 preset code", int'(baud_code), 'h13);
    pulse_go(32'd100_000_000, 32'd1000);
    check("R7 busy during search", int'(srch_busy), 1);
    wait_done();
    check("R7 done implies not busy", int'(srch_busy), 0);
    @(negedge clk);
    check("R7 done is one cycle", int'(srch_done), 0);
    check("R6 no fit gives 0x44", int'(baud_code), 'h44);

    // new code written mid-period: the current period keeps 288
    do @(negedge clk); while (!tick);
    gap_v = 0;
    do begin
      @(negedge clk);
      gap_v++;
      if (gap_v == 10) begin
        baud_we = 1'b1;
        baud_wdata = 7'h09;
      end else begin
        baud_we = 1'b0;
      end
    end while (!tick && gap_v < 10000);
    check("R3 period in flight unchanged", gap_v, 288);
    measure_gap(gap_v);
    check("R1 R3 code 0x09 period 8", gap_v, 8);
    write_code(7'h7F);
    measure_gap(gap_v);
    measure_gap(gap_v);
    check("R1 code 0x7F period 4096", gap_v, 4096);
    write_code(7'h00);
    measure_gap(gap_v);
    measure_gap(gap_v);
    check("R1 code 0x00 period 2", gap_v, 2);

    // soft reset beats a write in the same cycle
    @(negedge clk);
    soft_rst = 1'b1;
    baud_we = 1'b1;
    baud_wdata = 7'h55;
    @(negedge clk);
    soft_rst = 1'b0;
    baud_we = 1'b0;
    check("R2 soft reset over write", int'(baud_code), 'h44);
    measure_gap(gap_v);
    check("R2 period after soft reset", gap_v, 288);

    // soft reset aborts a search
    write_code(7'h21);
    pulse_go(32'd100_000_000, 32'd100_000);
    repeat (100) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check("R2 abort clears busy", int'(srch_busy), 0);
    done_seen = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (srch_done) done_seen++;
    end
    check("R2 no done after abort", done_seen, 0);
    check("R2 code after abort", int'(baud_code), 'h44);

    // second go while busy is ignored
    pulse_go(32'd100_000_000, 32'd100_000);
    repeat (50) @(negedge clk);
    pulse_go(32'd100_000_000, 32'd2_500_000);
    wait_done();
    @(negedge clk);
    check("R9 go while busy ignored", int'(baud_code), 'h62);

    // write lands on the commit edge
    pulse_go(32'd100_000_000, 32'd2_500_000);
    wait_done();
    baud_we = 1'b1;
    baud_wdata = 7'h2C;
    @(negedge clk);
    baud_we = 1'b0;
    check("R8 write wins over commit", int'(baud_code), 'h2C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule